// File: doc/BRIEF.md
# Sign-Aware PWM Channel

This block drives one pulse-width-modulated output and its companion direction pin from a duty word held in a local value register. A free-running ramp, advanced by a programmable prescaler, is compared against the current duty on each clock. The comparison yields either one contiguous pulse per period (block waveform) or on-time spread evenly across the period (spread waveform). In spread mode the ramp is bit-reversed before the compare.

The value word is read either as two's-complement or as a plain unsigned number. In two's-complement form its magnitude sets the duty and its sign drives the direction pin. In unsigned form the host's own direction bit goes straight to the pin. Changes to the duty take effect only at a period boundary, so no runt pulse is produced. A channel enable and a chip-wide enable gate the output. A chip-wide clear strobe zeroes the duty.

Top module: `pwm_chan`

## Requirements
- R1: `pwm_o` is low in the cycle after any cycle in which `en_i` or `glob_en_i` is low.
- R2: With `wave_i`=0 (block), each period of 2^(VAL_W-1) ramp ticks carries exactly one high run, `duty` ticks long and starting at ramp zero.
- R3: With `wave_i`=1 (spread), the output is high while the bit-reversed ramp is below `duty`. The high time per period is still `duty` ticks (for example, a duty of half scale toggles on every tick).
- R4: With `fmt_i`=0 (signed), `duty` is the absolute value of the value word, and the most negative value gives full scale (always high). `dir_o` is the sign bit of the loaded value.
- R5: With `fmt_i`=1 (unsigned), `duty` is the value word shifted right by one bit, and `dir_o` equals `dir_i` in the same cycle.
- R6: `pwm_rb_o` always equals `pwm_o`.
- R7: A `glob_clr_i` pulse zeroes both the value register and the active duty. The output then stays low until a new value is written.
- R8: The ramp advances once every `rate_i`+1 clock cycles.
- R9: A value written mid-period does not alter the period in progress. It takes effect from the next ramp wrap.
- R10: After reset, `pwm_o`, `pwm_rb_o` and `dir_o` are low and the duty is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| wave_i | input | 1 | 0 = block pulse, 1 = spread pulse |
| fmt_i | input | 1 | 0 = signed value, 1 = unsigned value |
| dir_i | input | 1 | Host direction bit, used in unsigned mode |
| glob_en_i | input | 1 | Chip-wide PWM enable |
| glob_clr_i | input | 1 | Chip-wide duty clear strobe |
| rate_i | input | RATE_W | Prescaler limit; tick period is rate_i+1 clocks |
| val_we_i | input | 1 | Value register write strobe |
| val_i | input | VAL_W | Value word to write |
| pwm_o | output | 1 | PWM output |
| dir_o | output | 1 | Direction output |
| pwm_rb_o | output | 1 | Debug readback of the live PWM level |

## Verification
The bench measures high time and rising-edge count over a full period. This separates a block waveform from a spread waveform: a design that skipped the bit reversal would show one rise where ten or sixteen are expected. The most negative signed value must give a solid high. A naive absolute value that drops the carry would instead give zero duty. A mid-period write is checked by timing the running pulse: loading the shadow at once would stretch that pulse to the new length. A prescaler off by one would scale the high time wrongly at a non-zero rate. A clear that missed the active duty would leave the output pulsing after the strobe.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic {WAVE_BLOCK = 1'b0, WAVE_SPREAD = 1'b1} wave_e;
  typedef enum logic {FMT_SIGNED = 1'b0, FMT_UNSIGNED = 1'b1} fmt_e;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  // >= so a lowered rate cannot strand the counter above the limit
  assign tick_o = (cnt_q >= rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int RAMP_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic [RAMP_W-1:0] ramp_rev_o,
  output logic              wrap_o
);
  logic [RAMP_W-1:0] ramp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ramp_q <= '0;
    else if (tick_i) ramp_q <= ramp_q + 1'b1;
  end

  for (genvar b = 0; b < RAMP_W; b++) begin : g_rev
    assign ramp_rev_o[b] = ramp_q[RAMP_W-1-b];
  end

  assign ramp_o = ramp_q;
  assign wrap_o = tick_i && (&ramp_q);
endmodule

// File: rtl/pwm_duty_conv.sv
module pwm_duty_conv #(
  parameter int VAL_W = 16
) (
  input  logic [VAL_W-1:0]   val_i,
  input  pwm_chan_pkg::fmt_e fmt_i,
  output logic [VAL_W-1:0]   duty_o,
  output logic               neg_o
);
  import pwm_chan_pkg::*;
  logic [VAL_W-1:0] mag;

  // most negative input yields 2^(VAL_W-1), i.e. full scale
  assign mag = val_i[VAL_W-1] ? (~val_i + 1'b1) : val_i;

  always_comb begin
    if (fmt_i == FMT_UNSIGNED) begin
      duty_o = {1'b0, val_i[VAL_W-1:1]};
      neg_o  = 1'b0;
    end else begin
      duty_o = mag;
      neg_o  = val_i[VAL_W-1];
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int VAL_W  = 16,
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wave_i,
  input  logic              fmt_i,
  input  logic              dir_i,
  input  logic              glob_en_i,
  input  logic              glob_clr_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              val_we_i,
  input  logic [VAL_W-1:0]  val_i,
  output logic              pwm_o,
  output logic              dir_o,
  output logic              pwm_rb_o
);
  import pwm_chan_pkg::*;
  localparam int RAMP_W = VAL_W - 1;

  logic              tick, wrap, run, hit, sign_q, conv_neg, pwm_q;
  logic [RAMP_W-1:0] ramp_q, ramp_rev, cmp_ramp;
  logic [VAL_W-1:0]  val_q, conv_duty, duty_sh_q;
  wave_e             wave;
  fmt_e              fmt;

  assign wave = wave_e'(wave_i);
  assign fmt  = fmt_e'(fmt_i);

  pwm_prescale #(.RATE_W(RATE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_i(rate_i), .tick_o(tick)
  );

  pwm_ramp #(.RAMP_W(RAMP_W)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .ramp_o(ramp_q), .ramp_rev_o(ramp_rev), .wrap_o(wrap)
  );

  pwm_duty_conv #(.VAL_W(VAL_W)) u_conv (
    .val_i(val_q), .fmt_i(fmt), .duty_o(conv_duty), .neg_o(conv_neg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         val_q <= '0;
    else if (glob_clr_i) val_q <= '0;
    else if (val_we_i)   val_q <= val_i;
  end

  // shadow duty: reloaded only at ramp wrap to avoid runt pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_sh_q <= '0;
      sign_q    <= 1'b0;
    end else if (glob_clr_i) begin
      duty_sh_q <= '0;
      sign_q    <= 1'b0;
    end else if (wrap) begin
      duty_sh_q <= conv_duty;
      sign_q    <= conv_neg;
    end
  end

  assign cmp_ramp = (wave == WAVE_SPREAD) ? ramp_rev : ramp_q;
  assign hit      = ({1'b0, cmp_ramp} < duty_sh_q);
  assign run      = en_i && glob_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= run && hit;
  end

  assign pwm_o    = pwm_q;
  assign pwm_rb_o = pwm_q;
  assign dir_o    = (fmt == FMT_UNSIGNED) ? dir_i : sign_q;
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int VAL_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               glob_en_i,
  input logic               glob_clr_i,
  input logic               tick,
  input logic               wrap,
  input logic [VAL_W-2:0]   ramp_q,
  input logic [VAL_W-1:0]   duty_sh_q,
  input logic [VAL_W-1:0]   val_q,
  input logic               pwm_o
);
  localparam logic [VAL_W-1:0] FULL = VAL_W'(1) << (VAL_W - 1);

  assert_gate_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && glob_en_i) |=> !pwm_o);

  assert_full_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && glob_en_i && duty_sh_q == FULL) |=> pwm_o);

  assert_zero_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_sh_q == '0) |=> !pwm_o);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_clr_i |=> (val_q == '0 && duty_sh_q == '0));

  assert_ramp_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> ramp_q == $past(ramp_q) + 1'b1);

  assert_ramp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(ramp_q));

  assert_shadow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wrap || glob_clr_i) |=> $stable(duty_sh_q));
endmodule

bind pwm_chan pwm_chan_chk #(.VAL_W(VAL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .glob_en_i(glob_en_i),
  .glob_clr_i(glob_clr_i), .tick(tick), .wrap(wrap), .ramp_q(ramp_q),
  .duty_sh_q(duty_sh_q), .val_q(val_q), .pwm_o(pwm_o)
);

// File: tb/pwm_chan_tb_top.sv
module pwm_chan_tb_top;
  localparam int VAL_W  = 6;
  localparam int RATE_W = 4;
  localparam int PER    = 1 << (VAL_W - 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 0, wave = 0, fmt = 0, dir = 0, gen = 0, clr = 0, we = 0;
  logic [RATE_W-1:0] rate = '0;
  logic [VAL_W-1:0]  val = '0;
  logic pwm, dir_o, rb;

  int total = 0, bad = 0, done_cnt = 0, issued = 0;

  typedef struct {string tag; int win; int exp_hi; int exp_rise;} item_t;
  item_t q[$];

  always #10 clk = ~clk;

  pwm_chan #(.VAL_W(VAL_W), .RATE_W(RATE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .wave_i(wave), .fmt_i(fmt),
    .dir_i(dir), .glob_en_i(gen), .glob_clr_i(clr), .rate_i(rate),
    .val_we_i(we), .val_i(val), .pwm_o(pwm), .dir_o(dir_o), .pwm_rb_o(rb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_val(input logic [VAL_W-1:0] v);
    @(negedge clk); val = v; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic settle();
    repeat (2 * PER * (int'(rate) + 1) + 4) @(negedge clk);
  endtask

  // driver: push expected window result, wait for monitor
  task automatic expect_win(input string tag, input int win, input int hi, input int rise);
    item_t it;
    it.tag = tag; it.win = win; it.exp_hi = hi; it.exp_rise = rise;
    issued++;
    q.push_back(it);
    wait (done_cnt == issued);
  endtask

  // monitor: pop and measure
  initial begin
    forever begin
      item_t it;
      int hi, rise, mm;
      logic prev;
      wait (q.size() > 0);
      it = q.pop_front();
      hi = 0; rise = 0; mm = 0;
      @(negedge clk); prev = pwm;
      for (int i = 0; i < it.win; i++) begin
        @(negedge clk);
        if (pwm && !prev) rise++;
        if (pwm) hi++;
        if (rb !== pwm) mm++;
        prev = pwm;
      end
      chk({it.tag, " high"}, hi, it.exp_hi);
      chk({it.tag, " rises"}, rise, it.exp_rise);
      chk("R6 readback mismatches", mm, 0);
      done_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int run_len;
    repeat (3) @(negedge clk);
    chk("R10 pwm_o after reset", pwm, 0);
    chk("R10 dir_o after reset", dir_o, 0);
    chk("R10 rb after reset", rb, 0);
    rst_ni = 1;
    @(negedge clk);
    en = 1; gen = 1;
    write_val(6'd10); settle();
    expect_win("R2 block duty 10", PER, 10, 1);

    wave = 1; settle();
    expect_win("R3 spread duty 10", PER, 10, 10);
    write_val(6'd16); settle();
    expect_win("R3 spread half scale", PER, 16, 16);
    wave = 0;

    write_val(6'd10); rate = 4'd2; settle();
    expect_win("R8 rate 2", 3 * PER, 30, 1);
    rate = '0;

    write_val(6'h36); settle();
    expect_win("R4 signed -10", PER, 10, 1);
    chk("R4 dir negative", dir_o, 1);
    write_val(6'h20); settle();
    expect_win("R4 most negative full", PER, PER, 0);
    chk("R4 dir most negative", dir_o, 1);
    write_val(6'd5); settle();
    chk("R4 dir positive", dir_o, 0);

    fmt = 1; dir = 1;
    write_val(6'h3F); settle();
    expect_win("R5 unsigned 0x3F", PER, 31, 1);
    chk("R5 dir follows 1", dir_o, 1);
    dir = 0; @(negedge clk);
    chk("R5 dir follows 0", dir_o, 0);
    write_val(6'h14); settle();
    expect_win("R5 unsigned 0x14", PER, 10, 1);

    en = 0; repeat (2) @(negedge clk);
    expect_win("R1 channel disabled", PER, 0, 0);
    en = 1; gen = 0; repeat (2) @(negedge clk);
    expect_win("R1 global disabled", PER, 0, 0);
    gen = 1; settle();
    expect_win("R1 re-enabled", PER, 10, 1);

    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    @(negedge clk);
    expect_win("R7 after clear", PER, 0, 0);
    settle();
    expect_win("R7 clear persists", PER, 0, 0);

    fmt = 0;
    write_val(6'd8); settle();
    // find a rising edge, write mid-pulse, time the pulse
    @(negedge clk);
    while (pwm) @(negedge clk);
    while (!pwm) @(negedge clk);
    run_len = 1;
    val = 6'd20; we = 1;
    @(negedge clk); we = 0;
    while (pwm) begin run_len++; @(negedge clk); end
    chk("R9 pulse in progress", run_len, 8);
    while (!pwm) @(negedge clk);
    run_len = 0;
    while (pwm) begin run_len++; @(negedge clk); end
    chk("R9 next pulse", run_len, 20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule